// File: doc/BRIEF.md
# Strobe-Driven FIFO with Flow-Through

This block is a first-in first-out buffer for 9-bit words that is driven by two active-low strobes instead of per-cycle enables. A word enters on the rising edge of the write strobe and leaves on the falling edge of the read strobe. Both strobes, together with an active-low retransmit strobe, are brought into the system clock domain by two-flop synchronisers. Each pointer update is triggered by an edge that is detected on the synchronised level. The depth is a parameter (2048 words by default, any power of two from 2048 to 65536 in use). Active-low flags report empty, full and more-than-half-full.

The read data port is driven only while the read strobe is low. Outside that window the port is high-impedance, which is modelled by a valid bit and a zeroed data bus. Two boundary sequences are defined. In read flow-through, the read strobe is already low on an empty buffer and a single write lets the reader take that word. In write flow-through, the write strobe is already low on a full buffer and a single read opens room for the pending word. Retransmit rewinds the reader to the first word written since reset.

Top module: `strobe_fifo`

## Requirements
- R1: While `rst_n` is low and right after it rises, `empty_n` is 0, `full_n` is 1, `half_n` is 1 and `dout_vld` is 0. Reset clears both pointers and the word count.
- R2: A rising edge of `wr_n` with fewer than DEPTH words stored writes `din` into the buffer. Words are read back in the order they were written. `din` must stay stable until 3 clock edges after `wr_n` rises.
- R3: `empty_n` is 0 exactly when no word is stored. `empty_n` and `full_n` are never both 0.
- R4: `full_n` is 0 whenever DEPTH words are stored. It is also 0 when DEPTH-1 words are stored and `wr_n` has been held low for at least one cycle at that count.
- R5: A rising edge of `wr_n` while DEPTH words are stored is ignored. Neither the data nor the count changes.
- R6: A falling edge of `rd_n` with at least one stored word removes the oldest word and presents it on `dout`. `dout_vld` is 1 only while the synchronised `rd_n` is low after such a read, and it is 0 (with `dout` = 0) otherwise.
- R7: `half_n` is 0 exactly when more than DEPTH/2 words are stored.
- R8: A falling edge of `rd_n` on an empty buffer moves no pointer. If `rd_n` then rises with no write in between, nothing is read.
- R9: Read flow-through applies when `rd_n` is low on an empty buffer and one word is written. The word is read one clock after it is stored: `empty_n` goes to 1 for exactly one cycle, then returns to 0, and the word is valid on `dout` until `rd_n` rises.
- R10: Write flow-through applies when `wr_n` is low on a full buffer and one word is read. `full_n` goes to 1 for exactly one cycle, then returns to 0. The pending word is stored on the next rising edge of `wr_n`.
- R11: A falling edge of `rt_n` while both `wr_n` and `rd_n` are high sets the read pointer to the first word and sets the count to the number of words written since reset (at most DEPTH). A retransmit edge while either strobe is low is ignored.
- R12: A strobe change takes effect on the third rising clock edge after it, and each strobe edge causes at most one pointer update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_n | input | 1 | Write strobe, active low; a word is stored on its rising edge |
| rd_n | input | 1 | Read strobe, active low; a word is taken on its falling edge |
| rt_n | input | 1 | Retransmit strobe, active low |
| din | input | 9 | Write data |
| dout | output | 9 | Read data, zero while not driven |
| dout_vld | output | 1 | High while `dout` is driven (low means high-impedance) |
| empty_n | output | 1 | Empty flag, active low |
| full_n | output | 1 | Full flag, active low |
| half_n | output | 1 | More-than-half-full flag, active low |

## Verification
Every strobe change goes through two synchroniser flops and one edge-detect flop, so a pointer or count update appears after the third rising edge that follows the change. `dout_vld` also drops two edges after `rd_n` rises. The bench drives strobes on falling clock edges and samples on falling edges, counting three edges before it looks at an updated flag or word. In the flow-through scenarios it samples on the third and the fourth edge separately, which catches the one-cycle flag pulses. Level checks otherwise wait four edges after a strobe change so that the result is settled.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;
  localparam int unsigned DW = 9;

  // more than half of the depth is stored
  function automatic logic over_half(input int unsigned cnt, input int unsigned depth);
    return cnt > (depth / 2);
  endfunction

  // a read goes ahead on a fresh falling edge, or on a pending one that is not being withdrawn
  function automatic logic read_go(input logic fall, input logic pend, input logic rise,
                                   input logic nonempty);
    return (fall | (pend & ~rise)) & nonempty;
  endfunction
endpackage

// File: rtl/strobe_fifo_sync.sv
module strobe_fifo_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic strb_n,
  output logic lvl,
  output logic lvl_d
);
  logic [2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= 3'b111;
    else        sh <= {sh[1:0], strb_n};
  end

  assign lvl   = sh[1];
  assign lvl_d = sh[2];
endmodule

// File: rtl/strobe_fifo_mem.sv
module strobe_fifo_mem #(
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned DW    = 9,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= cells[raddr];
  end
endmodule

// File: rtl/strobe_fifo_ctrl.sv
module strobe_fifo_ctrl import strobe_fifo_pkg::*; #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_rise,
  input  logic          wr_low,
  input  logic          rd_fall,
  input  logic          rd_rise,
  input  logic          rd_low,
  input  logic          rt_fall,
  output logic          wr_acc,
  output logic          rd_acc,
  output logic [AW-1:0] wp,
  output logic [AW-1:0] rp,
  output logic [CW-1:0] count,
  output logic          held,
  output logic          antic
);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);
  localparam logic [CW-1:0] NEARC = CW'(DEPTH - 1);

  logic          pend_q;
  logic [CW-1:0] total_q;
  logic          rt_acc;

  always_comb begin
    wr_acc = wr_rise & (count != FULLC);
    rd_acc = read_go(rd_fall, pend_q, rd_rise, count != '0);
    rt_acc = rt_fall & ~wr_low & ~rd_low & ~wr_rise & ~rd_rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0; total_q <= '0;
      pend_q <= 1'b0; held <= 1'b0; antic <= 1'b0;
    end else begin
      wp <= wp + AW'(wr_acc);
      if (wr_acc && total_q != FULLC) total_q <= total_q + 1'b1;
      if (rt_acc) begin
        rp     <= '0;
        count  <= total_q;
        pend_q <= 1'b0;
        held   <= 1'b0;
        antic  <= 1'b0;
      end else begin
        rp    <= rp + AW'(rd_acc);
        count <= count + CW'(wr_acc) - CW'(rd_acc);
        if (rd_acc || rd_rise) pend_q <= 1'b0;
        else if (rd_fall)      pend_q <= 1'b1;
        if (rd_rise)     held <= 1'b0;
        else if (rd_acc) held <= 1'b1;
        antic <= (count == NEARC) & wr_low;
      end
    end
  end
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo import strobe_fifo_pkg::*; #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic          rt_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_vld,
  output logic          empty_n,
  output logic          full_n,
  output logic          half_n
);
  localparam int unsigned NSTRB = 3;

  logic [NSTRB-1:0] raw_n, lvl, lvl_d;
  assign raw_n = {rt_n, rd_n, wr_n};

  for (genvar g = 0; g < NSTRB; g++) begin : g_sync
    strobe_fifo_sync u_sync (
      .clk(clk), .rst_n(rst_n), .strb_n(raw_n[g]), .lvl(lvl[g]), .lvl_d(lvl_d[g])
    );
  end

  // named edge events
  logic wr_rise, wr_low, rd_fall, rd_rise, rd_low, rt_fall;
  assign wr_rise = lvl[0] & ~lvl_d[0];
  assign wr_low  = ~lvl[0];
  assign rd_fall = ~lvl[1] & lvl_d[1];
  assign rd_rise = lvl[1] & ~lvl_d[1];
  assign rd_low  = ~lvl[1];
  assign rt_fall = ~lvl[2] & lvl_d[2];

  logic          wr_acc, rd_acc, held, antic;
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic [DW-1:0] q;

  strobe_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_rise(wr_rise), .wr_low(wr_low), .rd_fall(rd_fall), .rd_rise(rd_rise),
    .rd_low(rd_low), .rt_fall(rt_fall),
    .wr_acc(wr_acc), .rd_acc(rd_acc), .wp(wp), .rp(rp), .count(count),
    .held(held), .antic(antic)
  );

  strobe_fifo_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(wr_acc), .waddr(wp), .wdata(din),
    .re(rd_acc), .raddr(rp), .rdata(q)
  );

  assign dout_vld = held & rd_low;
  assign dout     = dout_vld ? q : '0;
  assign empty_n  = (count != '0);
  assign full_n   = ~((count == CW'(DEPTH)) | antic);
  assign half_n   = ~over_half(32'(count), DEPTH);
endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_n,
  input logic          empty_n,
  input logic          full_n,
  input logic          half_n,
  input logic          dout_vld,
  input logic          wr_edge,
  input logic          wr_acc,
  input logic          rd_acc,
  input logic [CW-1:0] count
);
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_full_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_edge && count == CW'(DEPTH) && !rd_acc) |=> (count == CW'(DEPTH)));

  assert_write_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && !rd_acc) |=> (count == $past(count) + 1'b1));

  assert_flags_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!empty_n && !full_n));

  assert_full_at_depth_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH)) |-> !full_n);

  assert_half_not_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !half_n |-> empty_n);

  assert_out_hiz_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dout_vld |-> !$past(rd_n, 2));

  assert_one_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> !rd_acc);
endmodule

bind strobe_fifo strobe_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .empty_n(empty_n), .full_n(full_n),
  .half_n(half_n), .dout_vld(dout_vld), .wr_edge(wr_rise), .wr_acc(wr_acc),
  .rd_acc(rd_acc), .count(count)
);

// File: tb/strobe_fifo_tb.sv
`timescale 1ns/1ps
module strobe_fifo_tb;
  localparam int DEPTH = 2048;
  localparam int HALF  = DEPTH / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic dout_vld, empty_n, full_n, half_n;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  strobe_fifo #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n), .din(din),
    .dout(dout), .dout_vld(dout_vld), .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  task automatic nedges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1;
    nedges(3);
    rst_n = 1'b1;
    nedges(4);
  endtask

  task automatic wr_word(input logic [8:0] d);
    din = d; wr_n = 1'b0;
    nedges(4);
    wr_n = 1'b1;
    nedges(4);
  endtask

  task automatic rd_word(output logic [8:0] d, output logic v);
    rd_n = 1'b0;
    nedges(4);
    d = dout; v = dout_vld;
    rd_n = 1'b1;
    nedges(4);
  endtask

  task automatic rd_expect(input string req, input logic [8:0] exp);
    logic [8:0] d; logic v;
    rd_word(d, v);
    check({req, " data"}, int'(d), int'(exp));
    check({req, " valid"}, int'(v), 1);
  endtask

  // R1
  task automatic t_reset();
    rst_n = 1'b0;
    nedges(2);
    check("R1 empty_n in reset", int'(empty_n), 0);
    check("R1 full_n in reset", int'(full_n), 1);
    rst_n = 1'b1;
    nedges(1);
    check("R1 half_n after reset", int'(half_n), 1);
    check("R1 dout_vld after reset", int'(dout_vld), 0);
  endtask

  // R2 R3 R6 R12
  task automatic t_basic();
    do_reset();
    din = 9'h101; wr_n = 1'b0;
    nedges(4);
    wr_n = 1'b1;
    nedges(2);
    check("R12 empty_n two edges after write", int'(empty_n), 0);
    nedges(1);
    check("R12 empty_n three edges after write", int'(empty_n), 1);
    nedges(3);
    for (int i = 1; i < 5; i++) wr_word(9'(9'h101 + i * 37));
    check("R3 empty_n with words stored", int'(empty_n), 1);
    rd_n = 1'b0;
    nedges(2);
    check("R6 not valid two edges after read", int'(dout_vld), 0);
    nedges(1);
    check("R6 valid three edges after read", int'(dout_vld), 1);
    check("R2 first word out", int'(dout), 'h101);
    rd_n = 1'b1;
    nedges(3);
    check("R6 hiz after rd_n rises", int'(dout_vld), 0);
    check("R6 dout zero when hiz", int'(dout), 0);
    nedges(2);
    for (int i = 1; i < 5; i++) rd_expect("R2 order", 9'(9'h101 + i * 37));
    check("R3 empty_n after drain", int'(empty_n), 0);
  endtask

  // R8
  task automatic t_empty_read();
    logic [8:0] d; logic v;
    do_reset();
    rd_word(d, v);
    check("R8 no valid on empty read", int'(v), 0);
    check("R8 still empty", int'(empty_n), 0);
    check("R8 no output after rise", int'(dout_vld), 0);
    wr_word(9'h055);
    check("R8 word kept after empty read", int'(empty_n), 1);
    rd_expect("R8 pointer unmoved", 9'h055);
    check("R8 empty after one read", int'(empty_n), 0);
  endtask

  // R7
  task automatic t_half();
    do_reset();
    for (int i = 0; i < HALF; i++) wr_word(9'(i));
    check("R7 half_n at exactly half", int'(half_n), 1);
    wr_word(9'(HALF));
    check("R7 half_n above half", int'(half_n), 0);
    rd_expect("R7 first word", 9'h000);
    check("R7 half_n back at half", int'(half_n), 1);
    for (int i = 1; i <= HALF; i++) rd_expect("R7 drain", 9'(i));
    check("R7 empty after drain", int'(empty_n), 0);
  endtask

  // R4 R5 R10
  task automatic t_full();
    do_reset();
    for (int i = 0; i < DEPTH; i++) wr_word(9'(i * 3));
    check("R4 full_n at depth", int'(full_n), 0);
    check("R3 empty_n when full", int'(empty_n), 1);
    wr_word(9'h1FF);
    check("R5 full_n after ignored write", int'(full_n), 0);
    // write flow-through
    din = 9'h0AA; wr_n = 1'b0;
    nedges(4);
    rd_n = 1'b0;
    nedges(3);
    check("R10 full_n released one cycle", int'(full_n), 1);
    check("R10 first word read", int'(dout), 0);
    nedges(1);
    check("R10 full_n asserted again", int'(full_n), 0);
    rd_n = 1'b1;
    nedges(4);
    check("R4 full_n held while write pending", int'(full_n), 0);
    wr_n = 1'b1;
    nedges(4);
    check("R10 full after pending write", int'(full_n), 0);
    for (int i = 1; i < DEPTH; i++) rd_expect("R5 drain", 9'(i * 3));
    rd_expect("R10 pending word last", 9'h0AA);
    check("R5 ignored word absent", int'(empty_n), 0);
  endtask

  // R9
  task automatic t_flow_read();
    do_reset();
    rd_n = 1'b0;
    nedges(6);
    check("R9 no data while waiting", int'(dout_vld), 0);
    din = 9'h133; wr_n = 1'b0;
    nedges(4);
    wr_n = 1'b1;
    nedges(3);
    check("R9 empty_n released one cycle", int'(empty_n), 1);
    nedges(1);
    check("R9 empty_n asserted again", int'(empty_n), 0);
    check("R9 word valid", int'(dout_vld), 1);
    check("R9 word value", int'(dout), 'h133);
    nedges(3);
    check("R9 word held while rd_n low", int'(dout), 'h133);
    rd_n = 1'b1;
    nedges(4);
    check("R9 hiz after rd_n rises", int'(dout_vld), 0);
  endtask

  task automatic rt_pulse();
    rt_n = 1'b0;
    nedges(4);
    rt_n = 1'b1;
    nedges(4);
  endtask

  // R11
  task automatic t_retx();
    do_reset();
    for (int i = 0; i < 4; i++) wr_word(9'(9'h010 + i));
    rd_expect("R11 pre read", 9'h010);
    rd_expect("R11 pre read", 9'h011);
    rd_n = 1'b0;
    nedges(4);
    check("R11 read under held strobe", int'(dout), 'h012);
    rt_pulse();
    rd_n = 1'b1;
    nedges(4);
    rd_expect("R11 ignored retransmit", 9'h013);
    check("R11 empty before retransmit", int'(empty_n), 0);
    rt_pulse();
    check("R11 count restored", int'(empty_n), 1);
    for (int i = 0; i < 4; i++) rd_expect("R11 replay", 9'(9'h010 + i));
    check("R11 empty after replay", int'(empty_n), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    t_reset();
    t_basic();
    t_empty_read();
    t_half();
    t_full();
    t_flow_read();
    t_retx();
    summary();
  end
endmodule